// File: doc/BRIEF.md
# Serial Switch-Control Register with Chain Output

This block is the digital front end of an eight-way analog switch array. A host writes a byte over a three-wire serial link made of an active-low frame select, a serial clock and a data line. Bits are collected in an 8-bit shift register on falling clock edges. When the frame select goes high, the collected byte is copied into the register that drives the eight switch enables. A serial output carries the bit that leaves the top of the shift register. Several blocks can therefore be chained so that one long frame loads all of them at once. The same output can also be used to read back the shift register.

The three serial pins are treated as asynchronous. Each one passes through a synchronizer into the system clock `clk_i`, and single-cycle edge strobes are derived from the synchronized levels, so all of the logic runs in one clock domain. The serial output is modelled as an open-drain pin. The block asserts `sdo_oe_o` to pull the line low for a 0 and releases it for a 1.

Top module: `swc_top`

## Requirements
- R1: While `rst_ni` is low, `sw_en_o` is 0 and `sdo_oe_o` is 1 (line pulled low). The shift register is also cleared, so a frame with no clocks sent after reset loads 0.
- R2: While the synchronized frame select is low, each falling edge of `sclk_i` shifts `sdi_i` into bit 0. After eight bits, the first bit sent sits in bit 7. Bit k of `sw_en_o` enables switch k+1, and a value of 1 closes that switch.
- R3: A frame may have any number of clocks. The byte that is loaded is always the last eight bits shifted in, and bits from the previous contents fill in when the frame is shorter than eight bits.
- R4: `sw_en_o` changes only on a rising edge of frame select. During a frame it keeps its previous value.
- R5: While frame select is high, toggling `sclk_i` and `sdi_i` leaves the shift register unchanged.
- R6: On each rising edge of `sclk_i` inside a frame, the serial output takes the current bit 7. `sdo_oe_o` is then 1 when that bit is 0, so the output trails the input by eight clocks.
- R7: A frame-select pulse with no clocks reloads `sw_en_o` from the unchanged shift register.
- R8: A rise of `fsel_ni` between clock edges reaches `sw_en_o` on the third rising edge of `clk_i` and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| fsel_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in, first bit first |
| sw_en_o | output | 8 | Switch enables; bit k drives switch k+1 |
| sdo_oe_o | output | 1 | Open-drain pull-down enable for the serial output |

## Verification
Full-byte frames use alternating, all-ones, all-zeros and end-bits-only patterns. Any bit-order or bit-position error shows up as a wrong enable. Short frames (1 and 3 bits) and long frames (13 and 16 bits) separate "keep the last eight" from "keep the first eight" or "clear at frame start". The long frames also exercise the chain output, which must replay the earlier bits eight clocks later. Idle clocking with frame select high, followed by a frame with no clocks, separates "clocks ignored" from "clocks shifted". Sampling the enables on the second and third system clock edges after frame select rises pins the update to the frame-end edge.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int unsigned SW_COUNT   = 8;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned PIN_COUNT  = 3;
  localparam int unsigned IDX_SCLK   = 0;
  localparam int unsigned IDX_FSEL   = 1;
  localparam int unsigned IDX_SDI    = 2;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  for (genvar b = 0; b < W; b++) begin : g_chk
    // strobe only after the pin itself has moved, STAGES cycles earlier
    p_rise_from_pin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[b] |-> $past(pin_i[b], STAGES));
    p_fall_from_pin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o[b] |-> !$past(pin_i[b], STAGES));
  end
endmodule

// File: rtl/swc_shifter.sv
module swc_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fsel_ni,
  input  logic         sclk_fall_i,
  input  logic         sclk_rise_i,
  input  logic         sdi_i,
  output logic [W-1:0] shreg_o,
  output logic         sdo_o
);
  logic [W-1:0] shreg_q;
  logic         sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      sdo_q   <= 1'b0;
    end else begin
      if (sclk_fall_i && !fsel_ni) shreg_q <= {shreg_q[W-2:0], sdi_i};
      if (sclk_rise_i && !fsel_ni) sdo_q <= shreg_q[W-1];
    end
  end

  assign shreg_o = shreg_q;
  assign sdo_o   = sdo_q;

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsel_ni |=> $stable(shreg_q));
  p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall_i && !fsel_ni) |=> shreg_q[0] == $past(sdi_i));
  p_sdo_msb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise_i && !fsel_ni) |=> sdo_q == $past(shreg_q[W-1]));
endmodule

// File: rtl/swc_latch.sv
module swc_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame_end_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sw_o
);
  logic [W-1:0] sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sw_q <= '0;
    else if (frame_end_i) sw_q <= data_i;
  end

  assign sw_o = sw_q;

  p_only_at_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(sw_q));
  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> sw_q == $past(data_i));
endmodule

// File: rtl/swc_top.sv
module swc_top
  import swc_pkg::*;
#(
  parameter int unsigned N_SW   = SW_COUNT,
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic            fsel_ni,
  input  logic            sdi_i,
  output logic [N_SW-1:0] sw_en_o,
  output logic            sdo_oe_o
);
  localparam logic [PIN_COUNT-1:0] PIN_IDLE =
    PIN_COUNT'((1 << IDX_SCLK) | (1 << IDX_FSEL));

  logic [PIN_COUNT-1:0] pins, lvl, rise, fall;
  logic [N_SW-1:0]      shreg;
  logic                 sdo;

  always_comb begin
    pins = '0;
    pins[IDX_SCLK] = sclk_i;
    pins[IDX_FSEL] = fsel_ni;
    pins[IDX_SDI]  = sdi_i;
  end

  swc_sync #(.W(PIN_COUNT), .STAGES(STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i, .rst_ni, .pin_i(pins), .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  swc_shifter #(.W(N_SW)) u_shift (
    .clk_i, .rst_ni,
    .fsel_ni(lvl[IDX_FSEL]),
    .sclk_fall_i(fall[IDX_SCLK]),
    .sclk_rise_i(rise[IDX_SCLK]),
    .sdi_i(lvl[IDX_SDI]),
    .shreg_o(shreg),
    .sdo_o(sdo)
  );

  swc_latch #(.W(N_SW)) u_latch (
    .clk_i, .rst_ni,
    .frame_end_i(rise[IDX_FSEL]),
    .data_i(shreg),
    .sw_o(sw_en_o)
  );

  assign sdo_oe_o = ~sdo;

  p_reset_open_r1: assert property (@(posedge clk_i) !rst_ni |-> sw_en_o == '0);
endmodule

// File: tb/swc_top_test.sv
module swc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  localparam logic [15:0] V_WORD [NV] = '{16'h00A5, 16'h005A, 16'h00FF, 16'h0000,
                                          16'h0081, 16'h0003, 16'h1234, 16'h0001, 16'hBEEF};
  localparam int V_LEN [NV] = '{8, 8, 8, 8, 8, 3, 16, 1, 13};

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, fsel_n = 1'b1, sdi = 1'b0;
  logic [7:0] sw_en;
  logic sdo_oe;
  logic [7:0] model = '0;
  logic [7:0] latched = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swc_top uut (.clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .fsel_ni(fsel_n),
               .sdi_i(sdi), .sw_en_o(sw_en), .sdo_oe_o(sdo_oe));

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    wait_n(2);
    sclk = 1'b0;
    model = {model[6:0], b};
    wait_n(5);
    sclk = 1'b1;
    wait_n(5);
    // R6: output drives low exactly when the MSB is 0
    check(sdo_oe == ~model[7], "R6", {7'd0, sdo_oe}, {7'd0, ~model[7]});
  endtask

  task automatic end_frame(input string req);
    fsel_n = 1'b1;
    wait_n(2);
    check(sw_en == latched, "R8 early", sw_en, latched);
    wait_n(1);
    check(sw_en == model, req, sw_en, model);
    latched = model;
    wait_n(3);
  endtask

  task automatic frame(input logic [15:0] w, input int n, input string req);
    fsel_n = 1'b0;
    wait_n(5);
    for (int i = n - 1; i >= 0; i--) begin
      send_bit(w[i]);
      if (i == n - 1) check(sw_en == latched, "R4", sw_en, latched);
    end
    end_frame(req);
  endtask

  initial begin
    wait_n(3);
    check(sw_en == 8'h00, "R1", sw_en, 8'h00);
    check(sdo_oe == 1'b1, "R1", {7'd0, sdo_oe}, 8'h01);
    rst_n = 1'b1;
    wait_n(5);

    for (int v = 0; v < NV; v++)
      frame(V_WORD[v], V_LEN[v], V_LEN[v] == 8 ? "R2" : "R3");

    // R5: clocking with frame select high must not move the shift register
    for (int i = 0; i < 10; i++) begin
      sdi = i[0];
      sclk = 1'b0; wait_n(4);
      sclk = 1'b1; wait_n(4);
    end
    check(sw_en == latched, "R5", sw_en, latched);
    // R7: zero-clock frame reloads the unchanged byte
    fsel_n = 1'b0;
    wait_n(6);
    end_frame("R5/R7");

    // a fresh byte, then reset in the middle of the next frame
    frame(16'h00C3, 8, "R2");
    fsel_n = 1'b0;
    wait_n(5);
    send_bit(1'b1);
    send_bit(1'b0);
    rst_n = 1'b0;
    fsel_n = 1'b1;
    wait_n(2);
    check(sw_en == 8'h00, "R1", sw_en, 8'h00);
    rst_n = 1'b1;
    model = '0;
    latched = '0;
    wait_n(5);
    fsel_n = 1'b0;
    wait_n(6);
    end_frame("R1 R7");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=00 exp=01");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule